// File: doc/BRIEF.md
# Multi-Port Shared Word Store with Selectable Access Discipline

This block is a single-cycle word memory reached through several request ports. In any cycle, each port may read or write any word. A two-bit mode input selects the access discipline. It decides whether several ports may share one address in a cycle for reads, for writes, for both, or for neither. When writes may share an address, a one-bit policy input chooses how a collision among writers is settled. One policy lets the lowest-numbered writer win. The other lets the write land only when all colliders carry identical data.

Responses come back in the same cycle. Each port gets a grant bit and an error bit. A read port also gets the addressed word. Granted writes update storage at the next rising clock edge. Any access that breaks the current discipline is refused, raises that port's error bit and leaves storage untouched. Ports that hit different addresses never interfere with each other. A read and a write to one word in the same cycle are not a conflict, and the read sees the value held before the write.

Top module: `multiport_cc_mem`

## Requirements
- R1: In every mode, a valid request whose address no other valid request of the same kind (read or write) shares that cycle is granted with no error.
- R2: With mode_i bit 0 clear (reads may not share), every read that shares its address with another read that cycle gets err=1, grant=0 and read data 0.
- R3: With mode_i bit 0 set (reads may share), every read is granted and returns the addressed word's current contents, whether or not other ports read the same word.
- R4: With mode_i bit 1 clear (writes may not share), every write that shares its address with another write that cycle gets err=1 and grant=0, and the word keeps its old value.
- R5: With mode_i bit 1 set and policy_i=0, only the lowest-numbered port among colliding writers is granted and its data is stored. The other colliders get grant=0 and err=0.
- R6: With mode_i bit 1 set and policy_i=1, colliding writers that all present equal data are all granted and that value is stored. If any data differs, none is granted, none errs, and the word is unchanged.
- R7: A read and a write to the same word in one cycle are both granted. The read returns the old value, and the new value is readable from the next cycle on.
- R8: After reset, every word reads as 0. A port without valid returns grant=0, err=0 and read data 0.
- R9: A port whose valid is low has no effect on storage or on the grants and errors of other ports, even when its write enable, address and data are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; granted writes land on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears every word |
| mode_i | input | 2 | Bit 0: reads may share an address; bit 1: writes may share an address |
| policy_i | input | 1 | Shared-write resolution: 0 lowest port wins, 1 all data must agree |
| req_valid_i | input | NPORTS | Per-port request valid |
| req_we_i | input | NPORTS | Per-port write enable (1 write, 0 read) |
| req_addr_i | input | NPORTS*AW | Per-port word address, port p in bits [p*AW +: AW] |
| req_wdata_i | input | NPORTS*DW | Per-port write data, port p in bits [p*DW +: DW] |
| rsp_rdata_o | output | NPORTS*DW | Per-port read data, port p in bits [p*DW +: DW]; 0 unless a read is granted |
| rsp_grant_o | output | NPORTS | Per-port grant in the request cycle |
| rsp_err_o | output | NPORTS | Per-port discipline violation in the request cycle |

## Verification
The bench builds the block with four ports, a 16-word store and 8-bit words. Four ports are enough for three-way write collisions where the winner is neither the first nor the last port, and for a read and a write overlapping on one word. The random phase draws addresses from only four words and data from only four values. Same-address collisions, equal-data agreements and differing-data refusals therefore occur often, in all four modes and both policies.

// File: rtl/mcm_pkg.sv
`timescale 1ns/1ps
package mcm_pkg;

  // Per-port collision findings produced by the detector.
  typedef struct packed {
    logic rd_shared;    // another valid read targets the same word
    logic wr_shared;    // another valid write targets the same word
    logic wr_outranked; // a lower-numbered write targets the same word
    logic wr_mismatch;  // another write to the same word carries other data
  } clash_t;

  typedef enum logic {
    WPOL_LOWEST = 1'b0,
    WPOL_AGREE  = 1'b1
  } wr_policy_e;

  function automatic logic reads_may_share(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic writes_may_share(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic logic same_word(input logic [31:0] a, input logic [31:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/mcm_clash_detect.sv
`timescale 1ns/1ps
module mcm_clash_detect
  import mcm_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic [NPORTS-1:0]    valid_i,
  input  logic [NPORTS-1:0]    we_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS*DW-1:0] wdata_i,
  output clash_t [NPORTS-1:0]  clash_o
);

  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      clash_o[i] = '0;
      for (int j = 0; j < NPORTS; j++) begin
        if (j != i && valid_i[i] && valid_i[j] &&
            same_word(32'(addr_i[i*AW +: AW]), 32'(addr_i[j*AW +: AW]))) begin
          if (!we_i[i] && !we_i[j]) clash_o[i].rd_shared = 1'b1;
          if (we_i[i] && we_i[j]) begin
            clash_o[i].wr_shared = 1'b1;
            if (j < i) clash_o[i].wr_outranked = 1'b1;
            if (wdata_i[j*DW +: DW] != wdata_i[i*DW +: DW]) clash_o[i].wr_mismatch = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mcm_resolve.sv
`timescale 1ns/1ps
module mcm_resolve
  import mcm_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic [1:0]          mode_i,
  input  logic                policy_i,
  input  logic [NPORTS-1:0]   valid_i,
  input  logic [NPORTS-1:0]   we_i,
  input  clash_t [NPORTS-1:0] clash_i,
  output logic [NPORTS-1:0]   grant_o,
  output logic [NPORTS-1:0]   err_o,
  output logic [NPORTS-1:0]   commit_o
);

  logic share_rd, share_wr;
  wr_policy_e pol;

  assign share_rd = reads_may_share(mode_i);
  assign share_wr = writes_may_share(mode_i);
  assign pol      = wr_policy_e'(policy_i);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic is_rd, is_wr, wr_win;
    assign is_rd = valid_i[p] & ~we_i[p];
    assign is_wr = valid_i[p] &  we_i[p];

    always_comb begin
      if (!clash_i[p].wr_shared)       wr_win = 1'b1;
      else if (pol == WPOL_LOWEST)     wr_win = ~clash_i[p].wr_outranked;
      else                             wr_win = ~clash_i[p].wr_mismatch;
    end

    always_comb begin
      grant_o[p] = 1'b0;
      err_o[p]   = 1'b0;
      if (is_rd) begin
        if (clash_i[p].rd_shared && !share_rd) err_o[p]   = 1'b1;
        else                                   grant_o[p] = 1'b1;
      end else if (is_wr) begin
        if (clash_i[p].wr_shared && !share_wr) err_o[p]   = 1'b1;
        else                                   grant_o[p] = wr_win;
      end
    end

    assign commit_o[p] = is_wr & grant_o[p];
  end

endmodule

// File: rtl/mcm_store.sv
`timescale 1ns/1ps
module mcm_store #(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    commit_i,
  input  logic [NPORTS-1:0]    rd_en_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS*DW-1:0] wdata_i,
  output logic [NPORTS*DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  // Conflicting commits to one word are excluded upstream, so loop order is free.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) words[k] <= '0;
    end else begin
      for (int i = 0; i < NPORTS; i++)
        if (commit_i[i]) words[addr_i[i*AW +: AW]] <= wdata_i[i*DW +: DW];
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    assign rdata_o[p*DW +: DW] = rd_en_i[p] ? words[addr_i[p*AW +: AW]] : '0;
  end

endmodule

// File: rtl/multiport_cc_mem.sv
`timescale 1ns/1ps
module multiport_cc_mem
  import mcm_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic                 policy_i,
  input  logic [NPORTS-1:0]    req_valid_i,
  input  logic [NPORTS-1:0]    req_we_i,
  input  logic [NPORTS*AW-1:0] req_addr_i,
  input  logic [NPORTS*DW-1:0] req_wdata_i,
  output logic [NPORTS*DW-1:0] rsp_rdata_o,
  output logic [NPORTS-1:0]    rsp_grant_o,
  output logic [NPORTS-1:0]    rsp_err_o
);

  clash_t [NPORTS-1:0] clash;
  logic   [NPORTS-1:0] commit;
  logic   [NPORTS-1:0] rd_en;

  mcm_clash_detect #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_detect (
    .valid_i (req_valid_i),
    .we_i    (req_we_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .clash_o (clash)
  );

  mcm_resolve #(.NPORTS(NPORTS)) u_resolve (
    .mode_i   (mode_i),
    .policy_i (policy_i),
    .valid_i  (req_valid_i),
    .we_i     (req_we_i),
    .clash_i  (clash),
    .grant_o  (rsp_grant_o),
    .err_o    (rsp_err_o),
    .commit_o (commit)
  );

  assign rd_en = rsp_grant_o & req_valid_i & ~req_we_i;

  mcm_store #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .rd_en_i  (rd_en),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .rdata_o  (rsp_rdata_o)
  );

endmodule

// File: rtl/mcm_checker.sv
`timescale 1ns/1ps
module mcm_checker
  import mcm_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode_i,
  input logic                policy_i,
  input logic [NPORTS-1:0]   valid,
  input logic [NPORTS-1:0]   we,
  input logic [NPORTS-1:0]   grant,
  input logic [NPORTS-1:0]   err,
  input logic [NPORTS-1:0]   commit,
  input clash_t [NPORTS-1:0] clash
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_LONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && !clash[p].rd_shared && !clash[p].wr_shared) |-> (grant[p] && !err[p])); // R1
    AST_EXCL_RD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && !we[p] && !mode_i[0] && clash[p].rd_shared) |-> (err[p] && !grant[p])); // R2
    AST_SHARED_RD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && !we[p] && mode_i[0]) |-> grant[p]); // R3
    AST_EXCL_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && we[p] && !mode_i[1] && clash[p].wr_shared) |-> (err[p] && !commit[p])); // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit[p] && mode_i[1] && !policy_i) |-> !clash[p].wr_outranked); // R5
    AST_AGREE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[p] && we[p] && mode_i[1] && policy_i && clash[p].wr_shared)
        |-> (grant[p] == !clash[p].wr_mismatch && !err[p])); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !valid[p] |-> (!grant[p] && !err[p] && !commit[p])); // R9
    AST_ERR_NOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !(err[p] && grant[p])); // R2
  end

endmodule

bind multiport_cc_mem mcm_checker #(.NPORTS(NPORTS)) u_mcm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .policy_i (policy_i),
  .valid    (req_valid_i),
  .we       (req_we_i),
  .grant    (rsp_grant_o),
  .err      (rsp_err_o),
  .commit   (commit),
  .clash    (clash)
);

// File: tb/tb_multiport_cc_mem.sv
`timescale 1ns/1ps
module tb_multiport_cc_mem;

  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] b_mode = 2'b00;
  logic b_pol = 1'b0;
  logic [NP-1:0] b_v = '0, b_we = '0;
  logic [AW-1:0] b_a [NP];
  logic [DW-1:0] b_d [NP];
  logic [NP*AW-1:0] addr_flat;
  logic [NP*DW-1:0] data_flat;
  logic [NP*DW-1:0] o_rd;
  logic [NP-1:0] o_gnt, o_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      addr_flat[i*AW +: AW] = b_a[i];
      data_flat[i*DW +: DW] = b_d[i];
    end
  end

  multiport_cc_mem #(.NPORTS(NP), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(b_mode), .policy_i(b_pol),
    .req_valid_i(b_v), .req_we_i(b_we), .req_addr_i(addr_flat), .req_wdata_i(data_flat),
    .rsp_rdata_o(o_rd), .rsp_grant_o(o_gnt), .rsp_err_o(o_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    b_v = '0; b_we = '0;
    for (int i = 0; i < NP; i++) begin b_a[i] = '0; b_d[i] = '0; end
  endtask

  task automatic req(input int p, input logic w, input int a, input int d);
    b_v[p] = 1'b1; b_we[p] = w; b_a[p] = AW'(a); b_d[p] = DW'(d);
  endtask

  // New cycle: inputs change at the falling edge, outputs sampled 1 ns later.
  task automatic new_cycle();
    @(negedge clk); idle_all();
  endtask

  function automatic logic [DW-1:0] rd_of(input int p);
    return o_rd[p*DW +: DW];
  endfunction

  task automatic read_word(input int a, output logic [DW-1:0] val);
    new_cycle(); req(0, 1'b0, a, 0); #1; val = rd_of(0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    new_cycle(); #1;
    check("R8 grant idle", 32'(o_gnt), 0);
    check("R8 err idle", 32'(o_err), 0);
    check("R8 rdata idle", 32'(o_rd), 0);
    read_word(0, v);  check("R8 word0", 32'(v), 0);
    read_word(15, v); check("R8 word15", 32'(v), 0);
  endtask

  task automatic t_random();
    logic [DW-1:0] nxt [DEPTH];
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = '0;
    for (int it = 0; it < 400; it++) begin
      new_cycle();
      b_mode = 2'($urandom % 4); b_pol = 1'($urandom % 2);
      for (int p = 0; p < NP; p++) begin
        b_v[p] = ($urandom % 4) != 0; b_we[p] = 1'($urandom % 2);
        b_a[p] = AW'($urandom % 4); b_d[p] = DW'($urandom % 4);
      end
      #1;
      for (int k = 0; k < DEPTH; k++) nxt[k] = ref_mem[k];
      for (int p = 0; p < NP; p++) begin
        logic shr, shw, low, dif, eg, ee;
        logic [DW-1:0] er;
        shr = 0; shw = 0; low = 0; dif = 0; eg = 0; ee = 0;
        for (int q = 0; q < NP; q++)
          if (q != p && b_v[q] && b_v[p] && b_a[q] == b_a[p]) begin
            if (!b_we[q] && !b_we[p]) shr = 1;
            if (b_we[q] && b_we[p]) begin
              shw = 1;
              if (q < p) low = 1;
              if (b_d[q] != b_d[p]) dif = 1;
            end
          end
        if (b_v[p] && !b_we[p]) begin
          if (shr && !b_mode[0]) ee = 1; else eg = 1;
        end else if (b_v[p]) begin
          if (!shw) eg = 1;
          else if (!b_mode[1]) ee = 1;
          else if (!b_pol) eg = !low;
          else eg = !dif;
        end
        er = (b_v[p] && !b_we[p] && eg) ? ref_mem[b_a[p]] : '0;
        check("random-model grant", 32'(o_gnt[p]), 32'(eg));
        check("random-model err", 32'(o_err[p]), 32'(ee));
        check("random-model rdata", 32'(rd_of(p)), 32'(er));
        if (b_v[p] && b_we[p] && eg) nxt[b_a[p]] = b_d[p];
      end
      for (int k = 0; k < DEPTH; k++) ref_mem[k] = nxt[k];
    end
    b_mode = 2'b00; b_pol = 1'b0;
  endtask

  task automatic t_distinct();
    for (int m = 0; m < 4; m += 3) begin
      new_cycle(); b_mode = 2'(m);
      for (int p = 0; p < NP; p++) req(p, 1'b1, 8 + p, 16 * m + p + 1);
      #1; check("R1 distinct writes granted", 32'(o_gnt), 32'hF);
      check("R1 distinct writes no err", 32'(o_err), 0);
      new_cycle();
      for (int p = 0; p < NP; p++) req(p, 1'b0, 8 + p, 0);
      #1; check("R1 distinct reads granted", 32'(o_gnt), 32'hF);
      for (int p = 0; p < NP; p++) check("R1 distinct read data", 32'(rd_of(p)), 32'(16 * m + p + 1));
    end
  endtask

  task automatic t_excl_read();
    for (int m = 0; m < 4; m += 2) begin
      new_cycle(); b_mode = 2'(m);
      req(0, 1'b0, 8, 0); req(2, 1'b0, 8, 0); req(1, 1'b0, 9, 0);
      #1; check("R2 shared read err", 32'(o_err), 32'b0101);
      check("R2 shared read grant", 32'(o_gnt), 32'b0010);
      check("R2 refused read data", 32'(rd_of(0)), 0);
      check("R1 lone read data", 32'(rd_of(1)), 32'h32);
    end
  endtask

  task automatic t_conc_read();
    new_cycle(); b_mode = 2'b01;
    for (int p = 0; p < NP; p++) req(p, 1'b0, 8, 0);
    #1; check("R3 all readers granted", 32'(o_gnt), 32'hF);
    for (int p = 0; p < NP; p++) check("R3 copy to each port", 32'(rd_of(p)), 32'h31);
  endtask

  task automatic t_excl_write();
    logic [DW-1:0] v;
    new_cycle(); b_mode = 2'b01;
    req(1, 1'b1, 9, 8'hA1); req(3, 1'b1, 9, 8'hB2);
    #1; check("R4 shared write err", 32'(o_err), 32'b1010);
    check("R4 shared write grant", 32'(o_gnt), 0);
    read_word(9, v); check("R4 word unchanged", 32'(v), 32'h32);
  endtask

  task automatic t_prio();
    logic [DW-1:0] v;
    new_cycle(); b_mode = 2'b10; b_pol = 1'b0;
    req(1, 1'b1, 5, 8'h11); req(2, 1'b1, 5, 8'h22); req(3, 1'b1, 5, 8'h33);
    #1; check("R5 lowest writer granted", 32'(o_gnt), 32'b0010);
    check("R5 losers no err", 32'(o_err), 0);
    read_word(5, v); check("R5 lowest data stored", 32'(v), 32'h11);
  endtask

  task automatic t_common();
    logic [DW-1:0] v;
    new_cycle(); b_mode = 2'b11; b_pol = 1'b1;
    req(0, 1'b1, 6, 8'h5A); req(2, 1'b1, 6, 8'h5A);
    #1; check("R6 agreeing writers granted", 32'(o_gnt), 32'b0101);
    read_word(6, v); check("R6 agreed value stored", 32'(v), 32'h5A);
    new_cycle(); b_mode = 2'b11; b_pol = 1'b1;
    req(0, 1'b1, 6, 8'h01); req(1, 1'b1, 6, 8'h01); req(3, 1'b1, 6, 8'h02);
    #1; check("R6 disagreeing none granted", 32'(o_gnt), 0);
    check("R6 disagreeing no err", 32'(o_err), 0);
    read_word(6, v); check("R6 word unchanged", 32'(v), 32'h5A);
    b_pol = 1'b0;
  endtask

  task automatic t_rw();
    logic [DW-1:0] v;
    new_cycle(); b_mode = 2'b00;
    req(0, 1'b0, 3, 0); req(1, 1'b1, 3, 8'hC3);
    #1; check("R7 both granted", 32'(o_gnt), 32'b0011);
    check("R7 read sees old data", 32'(rd_of(0)), 32'(ref_mem[3]));
    read_word(3, v); check("R7 new data next cycle", 32'(v), 32'hC3);
  endtask

  task automatic t_idle();
    logic [DW-1:0] v;
    new_cycle(); b_mode = 2'b00;
    b_we[2] = 1'b1; b_a[2] = 4'd4; b_d[2] = 8'hEE;
    req(0, 1'b1, 4, 8'h44);
    #1; check("R9 invalid port no grant", 32'(o_gnt[2]), 0);
    check("R9 invalid port no err", 32'(o_err[2]), 0);
    check("R9 valid writer unaffected", 32'(o_gnt[0]), 1);
    read_word(4, v); check("R9 invalid write has no effect", 32'(v), 32'h44);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_random();
    t_rw();
    t_distinct();
    t_excl_read();
    t_conc_read();
    t_excl_write();
    t_prio();
    t_common();
    t_idle();
    new_cycle();
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule